// File: doc/BRIEF.md
# Receive FIFO Link Flow Controller

This block decides when a serial link's receiver must throttle its remote peer. It adds the occupancy counts of the two inbound receive FIFOs. When the combined count reaches a programmable high-water mark, it asks the local transmitter to send a pause symbol. Once the count has drained to a lower, programmable low-water mark, it asks for a continue symbol. Because the two marks differ, there is hysteresis between them. Each request is raised once per change of throttle state. It is held, with its symbol kind, until the transmitter acknowledges it.

The same block also holds a small model of how the peer's sender reacts to these symbols. A received pause symbol arms a pending state. The sender enters the paused state on the first byte boundary that comes strictly after the cycle the pause arrived. While paused, every byte slot carries an idle symbol. A received continue symbol clears the paused state and any armed pause on the next cycle, and data then flows again. The line encoding and the FIFO storage are outside this block.

Top module: `rxq_flow_ctl`

## Requirements
- R1: After reset, `fc_req`, `throttle_on` and `peer_paused` are all 0.
- R2: While not throttled and with no request pending, a combined level `fifo0_level + fifo1_level >= high_mark` sets `throttle_on`, `fc_req` and `fc_pause` (1 = pause symbol) on the next clock edge.
- R3: A raised request keeps `fc_req` high and `fc_pause` unchanged until a cycle with `fc_ack` high; `fc_req` is low after that edge.
- R4: While throttled and with no request pending, a combined level `<= low_mark` clears `throttle_on` and raises `fc_req` with `fc_pause` = 0 (continue symbol) on the next edge.
- R5: A combined level strictly between the marks raises no request in either throttle state.
- R6: Once a pause request has been acknowledged, no further request is raised while the level stays at or above the high mark.
- R7: Both FIFO counts contribute to the decision: a level that is below the high mark in either FIFO alone still triggers a pause when the sum reaches it.
- R8: After `peer_rx_pause`, `peer_paused` sets at the first edge with `byte_tick` high that comes strictly after the reception cycle. A tick in the same cycle as the reception does not count.
- R9: While `peer_paused` is 1, every byte slot (`byte_tick` high) drives `slot_idle` = 1 and `slot_data` = 0, even when the peer has data.
- R10: `peer_rx_cont` clears `peer_paused` and any armed pause on the next edge, and it wins over a pause received in the same cycle. Afterwards, byte slots carry data (`slot_data` = 1) when `peer_has_data` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo0_level | input | LW | Word count of receive FIFO 0 |
| fifo1_level | input | LW | Word count of receive FIFO 1 |
| high_mark | input | SW | Combined level at which a pause is requested |
| low_mark | input | SW | Combined level at which a continue is requested |
| fc_ack | input | 1 | Transmitter has taken the pending request |
| fc_req | output | 1 | Flow-control symbol request to the transmitter |
| fc_pause | output | 1 | Kind of the requested symbol: 1 pause, 0 continue |
| throttle_on | output | 1 | Local throttle state (pause was decided) |
| peer_rx_pause | input | 1 | Pause symbol received by the peer sender model |
| peer_rx_cont | input | 1 | Continue symbol received by the peer sender model |
| byte_tick | input | 1 | Byte boundary strobe of the peer sender |
| peer_has_data | input | 1 | Peer sender has data to send |
| peer_paused | output | 1 | Peer sender is in the paused state |
| slot_idle | output | 1 | Current byte slot carries an idle symbol |
| slot_data | output | 1 | Current byte slot carries data |

## Verification
On every cycle, the assertions check the request handshake: the request is held until it is acknowledged, and it drops after the acknowledge. They also check that each change of throttle state comes with a request of the right kind, that a high level while running is acted on at once, that the paused state begins only after a byte tick, and that a continue clears the paused state. Hysteresis between the marks, the single request per state change, the same-cycle tick exclusion, and the summing of both FIFOs are shown only by the bench's directed scenarios.

// File: rtl/rxq_flow_ctl.sv
module rxq_flow_ctl #(
  parameter int DEPTH = 16,
  parameter int LW = $clog2(DEPTH + 1),
  parameter int SW = $clog2(2 * DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] fifo0_level,
  input  logic [LW-1:0] fifo1_level,
  input  logic [SW-1:0] high_mark,
  input  logic [SW-1:0] low_mark,
  input  logic          fc_ack,
  output logic          fc_req,
  output logic          fc_pause,
  output logic          throttle_on,
  input  logic          peer_rx_pause,
  input  logic          peer_rx_cont,
  input  logic          byte_tick,
  input  logic          peer_has_data,
  output logic          peer_paused,
  output logic          slot_idle,
  output logic          slot_data
);

  logic [SW-1:0] fill;
  logic          go_pause, go_cont, armed;

  assign fill     = SW'(fifo0_level) + SW'(fifo1_level);
  assign go_pause = !fc_req && !throttle_on && (fill >= high_mark);
  assign go_cont  = !fc_req &&  throttle_on && (fill <= low_mark);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      throttle_on <= 1'b0;
      fc_req      <= 1'b0;
      fc_pause    <= 1'b0;
    end else if (go_pause) begin
      throttle_on <= 1'b1;
      fc_req      <= 1'b1;
      fc_pause    <= 1'b1;
    end else if (go_cont) begin
      throttle_on <= 1'b0;
      fc_req      <= 1'b1;
      fc_pause    <= 1'b0;
    end else if (fc_ack) begin
      fc_req      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      peer_paused <= 1'b0;
    end else if (peer_rx_cont) begin
      armed       <= 1'b0;
      peer_paused <= 1'b0;
    end else begin
      if (armed && byte_tick) peer_paused <= 1'b1;
      if (peer_rx_pause)      armed <= 1'b1;
      else if (byte_tick)     armed <= 1'b0;
    end
  end

  assign slot_idle = byte_tick && (peer_paused || !peer_has_data);
  assign slot_data = byte_tick && !peer_paused && peer_has_data;

endmodule

// File: rtl/rxq_flow_ctl_chk.sv
module rxq_flow_ctl_chk #(
  parameter int LW = 5,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] fifo0_level,
  input logic [LW-1:0] fifo1_level,
  input logic [SW-1:0] high_mark,
  input logic          fc_ack,
  input logic          fc_req,
  input logic          fc_pause,
  input logic          throttle_on,
  input logic          peer_rx_cont,
  input logic          byte_tick,
  input logic          peer_paused
);
  logic [SW:0] sum;
  assign sum = (SW+1)'(fifo0_level) + (SW+1)'(fifo1_level);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fc_req && !fc_ack |=> fc_req && $stable(fc_pause)); // R3
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    fc_req && fc_ack |=> !fc_req); // R3
  AST_PAUSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(throttle_on) |-> fc_req && fc_pause); // R2
  AST_CONT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(throttle_on) |-> fc_req && !fc_pause); // R4
  AST_HIGH_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
    !throttle_on && !fc_req && sum >= (SW+1)'(high_mark) |=> throttle_on); // R2
  AST_PAUSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(peer_paused) |-> $past(byte_tick)); // R8
  AST_CONT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    peer_rx_cont |=> !peer_paused); // R10
endmodule

bind rxq_flow_ctl rxq_flow_ctl_chk #(.LW(LW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo0_level(fifo0_level), .fifo1_level(fifo1_level),
  .high_mark(high_mark), .fc_ack(fc_ack), .fc_req(fc_req), .fc_pause(fc_pause),
  .throttle_on(throttle_on), .peer_rx_cont(peer_rx_cont), .byte_tick(byte_tick),
  .peer_paused(peer_paused)
);

// File: tb/sim_rxq_flow_ctl.sv
`timescale 1ns/1ps
module sim_rxq_flow_ctl;
  localparam int LW = 5, SW = 6;
  logic clk = 0, rst_n = 0;
  logic [LW-1:0] f0 = 0, f1 = 0;
  logic [SW-1:0] hi = 6'd28, lo = 6'd8;
  logic ack = 0, rxp = 0, rxc = 0, tick = 0, has = 1;
  logic req, kind, thr, ppaused, sidle, sdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rxq_flow_ctl u0 (
    .clk(clk), .rst_n(rst_n), .fifo0_level(f0), .fifo1_level(f1),
    .high_mark(hi), .low_mark(lo), .fc_ack(ack), .fc_req(req), .fc_pause(kind),
    .throttle_on(thr), .peer_rx_pause(rxp), .peer_rx_cont(rxc), .byte_tick(tick),
    .peer_has_data(has), .peer_paused(ppaused), .slot_idle(sidle), .slot_data(sdata)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic levels(input int a, input int b);
    @(negedge clk); f0 = LW'(a); f1 = LW'(b);
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk(req, 0, "R3 req drops after ack");
  endtask

  task automatic t_reset();
    chk(req, 0, "R1 fc_req at reset");
    chk(thr, 0, "R1 throttle_on at reset");
    chk(ppaused, 0, "R1 peer_paused at reset");
  endtask

  task automatic t_pause();
    levels(14, 13);
    @(negedge clk); @(negedge clk);
    chk(req, 0, "R5 no request below high mark");
    levels(14, 14);
    @(negedge clk);
    chk(req, 1, "R2 pause request raised");
    chk(kind, 1, "R2 symbol is pause");
    chk(thr, 1, "R2 throttle set");
    repeat (3) @(negedge clk);
    chk(req, 1, "R3 request held without ack");
    chk(kind, 1, "R3 kind held");
    do_ack();
    levels(16, 14);
    repeat (3) @(negedge clk);
    chk(req, 0, "R6 single request while level stays high");
  endtask

  task automatic t_cont();
    levels(5, 5);
    repeat (3) @(negedge clk);
    chk(req, 0, "R5 no continue between marks");
    chk(thr, 1, "R5 still throttled between marks");
    levels(4, 4);
    @(negedge clk);
    chk(req, 1, "R4 continue request raised");
    chk(kind, 0, "R4 symbol is continue");
    chk(thr, 0, "R4 throttle cleared");
    do_ack();
  endtask

  task automatic t_sum();
    levels(16, 0);
    repeat (2) @(negedge clk);
    chk(req, 0, "R7 single fifo at 16 below mark");
    levels(16, 12);
    @(negedge clk);
    chk(req & kind, 1, "R7 sum of both fifos triggers pause");
    do_ack();
    levels(0, 0);
    @(negedge clk);
    chk(req & ~kind, 1, "R4 continue after drain");
    do_ack();
  endtask

  task automatic t_peer_pause();
    @(negedge clk); rxp = 1; tick = 1;
    @(negedge clk); rxp = 0; tick = 0;
    chk(ppaused, 0, "R8 same-cycle tick does not pause");
    @(negedge clk);
    chk(ppaused, 0, "R8 no pause without tick");
    tick = 1;
    @(negedge clk); tick = 0;
    chk(ppaused, 1, "R8 paused at first later tick");
    @(negedge clk); tick = 1; #1;
    chk(sidle, 1, "R9 slot idle while paused");
    chk(sdata, 0, "R9 no data while paused");
  endtask

  task automatic t_peer_cont();
    @(negedge clk); tick = 0; rxc = 1;
    @(negedge clk); rxc = 0;
    chk(ppaused, 0, "R10 continue clears pause");
    tick = 1; #1;
    chk(sdata, 1, "R10 data resumes");
    @(negedge clk); tick = 0; rxp = 1; rxc = 1;
    @(negedge clk); rxp = 0; rxc = 0; tick = 1;
    @(negedge clk); tick = 0;
    chk(ppaused, 0, "R10 continue wins over same-cycle pause");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pause();
    t_cont();
    t_sum();
    t_peer_pause();
    t_peer_cont();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule